// File: doc/BRIEF.md
# Three-Zone Gain and Offset Register Bank

This block holds the per-zone calibration settings of a line sensor controller whose pixel row is split into three equal zones. A serial command decoder upstream hands it already-decoded register writes (an address together with the data byte that followed the command byte) and register reads (an address). Each zone owns an 8-bit offset code in sign-magnitude form and a 5-bit gain code. A separate 8-bit mode word sits at the top of the address space, and one of its bits is a sleep flag.

Read replies leave the block after a fixed number of clock edges, ready for a transmit path to serialize them. Alongside the register file, a zone lookup turns a pixel index into that pixel's zone and drives the zone's current gain and offset codes to downstream conversion logic. The address map is sparse. Writes to unmapped addresses are dropped, and reads of unmapped addresses return zero.

Top module: `zone_regbank`

## Requirements
- R1: Addresses 0x00, 0x02 and 0x04 hold the left, center and right zone offset codes. All 8 bits of the data byte are stored unchanged, sign bit (bit 7) included, and read back unchanged.
- R2: Addresses 0x01, 0x03 and 0x05 hold the left, center and right zone gain codes. Only data bits 4:0 are stored, and a read returns bits 7:5 as zero.
- R3: Address 0x1F holds an 8-bit mode word that reads back in full. Output `sleep` equals bit 4 of the stored mode word. The other mode bits have no effect on any output.
- R4: A write to any address other than 0x00–0x05 and 0x1F changes no register. A read of such an address returns 0x00.
- R5: A read request is accepted at the rising edge where `rd_en` is high. `rd_valid` is high for exactly one cycle, starting at the rising edge RD_LAT-1 edges later (RD_LAT = 4 rising edges counting the accepting one). Requests may be accepted on consecutive edges, and their replies come back in order.
- R6: A read reply carries the register value as it stood before the accepting edge. A write to the same address at that same edge is not seen in the reply, but later reads do see it.
- R7: Pixel indices 0–33 select the left zone, 34–67 the center zone, and 68–101 the right zone. Indices above 101 select the right zone.
- R8: `zone_gain` and `zone_offset` follow `pix_idx` without a clock. They show a newly written code from the cycle after the write edge.
- R9: A synchronous active-high reset clears every register to zero and drops `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 5 | Read address |
| rd_valid | output | 1 | Read reply valid, one cycle |
| rd_data | output | 8 | Read reply byte |
| pix_idx | input | 7 | Pixel index for the zone lookup |
| zone_gain | output | 5 | Gain code of the selected pixel's zone |
| zone_offset | output | 8 | Offset code of the selected pixel's zone |
| sleep | output | 1 | Sleep flag from the mode word |

## Verification
A write and a read of the same register can land on the same clock edge. The reply must then carry the old value, and the next read must carry the new one. The bench issues both strobes in the same cycle for every mapped address and compares against a model that applies the write only after it has taken the read snapshot. A write can also coincide with a zone lookup of that zone. The bench holds a pixel index steady across a write and requires the lookup output to change exactly one cycle later.

// File: rtl/zone_regbank_pkg.sv
package zone_regbank_pkg;
    localparam int DATA_W    = 8;
    localparam int GAIN_W    = 5;
    localparam int NZ        = 3;
    localparam int ZI_W      = $clog2(NZ);
    localparam int SLEEP_BIT = 4;

    typedef struct packed {
        logic [NZ-1:0][DATA_W-1:0] offs;
        logic [NZ-1:0][GAIN_W-1:0] gain;
        logic [DATA_W-1:0]         mode;
    } regs_t;
endpackage

// File: rtl/zr_store.sv
module zr_store
    import zone_regbank_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MODE_ADDR = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic [ZI_W-1:0]   zone_idx,
    output logic [GAIN_W-1:0] zone_gain,
    output logic [DATA_W-1:0] zone_offset,
    output logic              sleep
);
    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d = '0;
        end else if (wr_en) begin
            for (int z = 0; z < NZ; z++) begin
                if (wr_addr == ADDR_W'(2 * z))
                    regs_d.offs[z] = wr_data;
                if (wr_addr == ADDR_W'(2 * z + 1))
                    regs_d.gain[z] = wr_data[GAIN_W-1:0];
            end
            if (wr_addr == ADDR_W'(MODE_ADDR))
                regs_d.mode = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    always_comb begin
        rd_word = '0;
        for (int z = 0; z < NZ; z++) begin
            if (rd_addr == ADDR_W'(2 * z))
                rd_word = regs_q.offs[z];
            if (rd_addr == ADDR_W'(2 * z + 1))
                rd_word = DATA_W'(regs_q.gain[z]);
        end
        if (rd_addr == ADDR_W'(MODE_ADDR))
            rd_word = regs_q.mode;
    end

    always_comb begin
        zone_gain   = '0;
        zone_offset = '0;
        for (int z = 0; z < NZ; z++) begin
            if (zone_idx == ZI_W'(z)) begin
                zone_gain   = regs_q.gain[z];
                zone_offset = regs_q.offs[z];
            end
        end
    end

    assign sleep = regs_q.mode[SLEEP_BIT];
endmodule

// File: rtl/zr_rd_pipe.sv
module zr_rd_pipe
    import zone_regbank_pkg::*;
#(
    parameter int RD_LAT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] word,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [RD_LAT-1:0]             vld_d, vld_q;
    logic [RD_LAT-1:0][DATA_W-1:0] dat_d, dat_q;

    always_comb begin
        vld_d    = vld_q;
        dat_d    = dat_q;
        vld_d[0] = req;
        dat_d[0] = word;
        for (int s = 1; s < RD_LAT; s++) begin
            vld_d[s] = vld_q[s-1];
            dat_d[s] = dat_q[s-1];
        end
        if (rst) begin
            vld_d = '0;
            dat_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        vld_q <= vld_d;
        dat_q <= dat_d;
    end

    assign rsp_valid = vld_q[RD_LAT-1];
    assign rsp_data  = dat_q[RD_LAT-1];
endmodule

// File: rtl/zr_zone_sel.sv
module zr_zone_sel
    import zone_regbank_pkg::*;
#(
    parameter int PIX_W    = 7,
    parameter int ZONE_PIX = 34
) (
    input  logic [PIX_W-1:0] pix_idx,
    output logic [ZI_W-1:0]  zone_idx
);
    always_comb begin
        zone_idx = ZI_W'(NZ - 1);
        for (int z = NZ - 2; z >= 0; z--) begin
            if (int'(pix_idx) < (z + 1) * ZONE_PIX)
                zone_idx = ZI_W'(z);
        end
    end
endmodule

// File: rtl/zone_regbank.sv
module zone_regbank
    import zone_regbank_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MODE_ADDR = 31,
    parameter int RD_LAT    = 4,
    parameter int PIX_W     = 7,
    parameter int ZONE_PIX  = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [PIX_W-1:0]  pix_idx,
    output logic [GAIN_W-1:0] zone_gain,
    output logic [DATA_W-1:0] zone_offset,
    output logic              sleep
);
    logic [DATA_W-1:0] rd_word;
    logic [ZI_W-1:0]   zone_idx;

    zr_zone_sel #(.PIX_W(PIX_W), .ZONE_PIX(ZONE_PIX)) u_sel (
        .pix_idx  (pix_idx),
        .zone_idx (zone_idx)
    );

    zr_store #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_word     (rd_word),
        .zone_idx    (zone_idx),
        .zone_gain   (zone_gain),
        .zone_offset (zone_offset),
        .sleep       (sleep)
    );

    zr_rd_pipe #(.RD_LAT(RD_LAT)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .req       (rd_en),
        .word      (rd_word),
        .rsp_valid (rd_valid),
        .rsp_data  (rd_data)
    );
endmodule

// File: rtl/zone_regbank_chk.sv
module zone_regbank_chk
    import zone_regbank_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int MODE_ADDR = 31,
    parameter int RD_LAT    = 4,
    parameter int PIX_W     = 7,
    parameter int ZONE_PIX  = 34
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [PIX_W-1:0]  pix_idx,
    input logic [GAIN_W-1:0] zone_gain,
    input logic [DATA_W-1:0] zone_offset,
    input logic              sleep
);
    logic [RD_LAT-1:0]             sh_v;
    logic [RD_LAT-1:0][ADDR_W-1:0] sh_a;
    logic [ADDR_W-1:0]             out_a;
    logic                          out_unmapped, out_gain;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_v <= '0;
            sh_a <= '0;
        end else begin
            sh_v <= {sh_v[RD_LAT-1:0], rd_en} >> 0 == 0 ? '0 : RD_LAT'({sh_v, rd_en});
            sh_a <= (RD_LAT*ADDR_W)'({sh_a, rd_addr});
        end
    end

    assign out_a        = sh_a[RD_LAT-1];
    assign out_unmapped = (out_a > ADDR_W'(2 * NZ - 1)) && (out_a != ADDR_W'(MODE_ADDR));
    assign out_gain     = (out_a < ADDR_W'(2 * NZ)) && out_a[0];

    p_rd_timing_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid == sh_v[RD_LAT-1]);

    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && out_unmapped) |-> rd_data == '0);

    p_gain_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && out_gain) |-> rd_data[DATA_W-1:GAIN_W] == '0);

    p_sleep_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) |=> sleep == $past(wr_data[SLEEP_BIT]));

    p_zone_left_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0 && int'(pix_idx) < ZONE_PIX)
        |=> (!$stable(pix_idx) || zone_offset == $past(wr_data)));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_valid && !sleep && zone_gain == '0 && zone_offset == '0));
endmodule

bind zone_regbank zone_regbank_chk #(
    .ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR), .RD_LAT(RD_LAT),
    .PIX_W(PIX_W), .ZONE_PIX(ZONE_PIX)
) u_chk (.*);

// File: tb/zone_regbank_bench.sv
module zone_regbank_bench;
    localparam int RD_LAT = 4;
    localparam int ZONE_PIX = 34;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [4:0] rd_addr = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [6:0] pix_idx = '0;
    logic [4:0] zone_gain;
    logic [7:0] zone_offset;
    logic       sleep;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [32];

    always #4 clk = ~clk;

    zone_regbank u_zone_regbank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .pix_idx(pix_idx), .zone_gain(zone_gain), .zone_offset(zone_offset), .sleep(sleep)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] stored(input logic [4:0] a, input logic [7:0] d);
        if (a == 5'h1F || a == 0 || a == 2 || a == 4) return d;
        if (a == 1 || a == 3 || a == 5) return {3'b000, d[4:0]};
        return 8'h00;
    endfunction

    function automatic bit mapped(input logic [4:0] a);
        return (a <= 5) || (a == 5'h1F);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 32; i++) model[i] = 8'h00;
    endtask

    task automatic do_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (mapped(a)) model[a] = stored(a, d);
    endtask

    // optional same-cycle write; reply checked against the pre-write model
    task automatic access(input bit do_wr, input logic [4:0] wa, input logic [7:0] wd,
                          input logic [4:0] ra, input string tag);
        logic [7:0] exp;
        exp = model[ra];
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ra;
        wr_en = do_wr; wr_addr = wa; wr_data = wd;
        for (int i = 1; i < RD_LAT; i++) begin
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
            check(rd_valid == 1'b0, "R5 early valid", rd_valid, 0);
        end
        if (do_wr && mapped(wa)) model[wa] = stored(wa, wd);
        @(negedge clk);
        check(rd_valid == 1'b1, "R5 valid", rd_valid, 1);
        check(rd_data == exp, tag, rd_data, exp);
        @(negedge clk);
        check(rd_valid == 1'b0, "R5 single cycle", rd_valid, 0);
    endtask

    task automatic zone_sweep(input string tag);
        for (int p = 0; p < 128; p++) begin
            int z;
            @(negedge clk);
            pix_idx = 7'(p);
            #1;
            z = (p < ZONE_PIX) ? 0 : (p < 2 * ZONE_PIX) ? 1 : 2;
            check(zone_offset == model[2 * z], {tag, " R7 offset"}, zone_offset, model[2 * z]);
            check(zone_gain == model[2 * z + 1][4:0], {tag, " R7 gain"}, zone_gain, model[2 * z + 1]);
        end
    endtask

    logic done = 1'b0;

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check(rd_valid == 1'b0, "R9 rd_valid", rd_valid, 0);
        check(sleep == 1'b0, "R9 sleep", sleep, 0);
        for (int a = 0; a < 32; a++) access(0, 0, 0, 5'(a), "R9 reset readback");

        // R1 R2 R3 R4: write all 32 addresses, read all back, two patterns
        for (int pat = 0; pat < 2; pat++) begin
            for (int a = 0; a < 32; a++) do_write(5'(a), 8'(a * 37 + 5 + pat * 128));
            for (int a = 0; a < 32; a++) access(0, 0, 0, 5'(a), "R1 R2 R3 R4 readback");
            zone_sweep("R7 R8");
        end

        // R3: sleep follows bit 4; other bits no effect
        do_write(5'h1F, 8'h10);
        check(sleep == 1'b1, "R3 sleep set", sleep, 1);
        do_write(5'h1F, 8'hEF);
        check(sleep == 1'b0, "R3 other bits", sleep, 0);
        access(0, 0, 0, 5'h1F, "R3 mode readback");

        // R1: sign-magnitude extremes stored as-is
        do_write(5'h00, 8'h80);
        do_write(5'h02, 8'h7F);
        do_write(5'h04, 8'hFF);
        for (int a = 0; a < 6; a += 2) access(0, 0, 0, 5'(a), "R1 sign codes");

        // R4: unmapped writes leave mapped registers intact
        for (int a = 6; a < 31; a++) do_write(5'(a), 8'hA5);
        for (int a = 0; a < 32; a++) access(0, 0, 0, 5'(a), "R4 after unmapped writes");

        // R6: same-edge write and read of every mapped address
        for (int a = 0; a < 32; a++) begin
            if (mapped(5'(a))) begin
                access(1, 5'(a), 8'(~(a * 11)), 5'(a), "R6 old value");
                access(0, 0, 0, 5'(a), "R6 new value");
            end
        end

        // R8: lookup changes one cycle after the write edge, index held
        @(negedge clk);
        pix_idx = 7'd50;
        wr_en = 1'b1; wr_addr = 5'd2; wr_data = 8'h3C;
        #1;
        check(zone_offset == model[2], "R8 before write", zone_offset, model[2]);
        @(negedge clk);
        wr_en = 1'b0;
        model[2] = 8'h3C;
        check(zone_offset == 8'h3C, "R8 after write", zone_offset, 8'h3C);

        // R5: back-to-back reads return in order
        begin
            logic [4:0] ra [3];
            ra[0] = 5'd1; ra[1] = 5'h1F; ra[2] = 5'd4;
            for (int c = 0; c < RD_LAT + 3; c++) begin
                @(negedge clk);
                if (c >= RD_LAT) begin
                    check(rd_valid == 1'b1, "R5 burst valid", rd_valid, 1);
                    check(rd_data == model[ra[c - RD_LAT]], "R5 burst order",
                          rd_data, model[ra[c - RD_LAT]]);
                end
                if (c < 3) begin rd_en = 1'b1; rd_addr = ra[c]; end
                else rd_en = 1'b0;
            end
        end

        // R9: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        check(sleep == 1'b0, "R9 sleep cleared", sleep, 0);
        for (int a = 0; a < 32; a++) access(0, 0, 0, 5'(a), "R9 cleared readback");
        zone_sweep("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule